// File: doc/BRIEF.md
# I2S Slave Frame-Start Synchronizer

This block lets the receive or transmit shifter of an I2S slave find the first frame after it is enabled. It samples the word-select line in the serial clock domain through a short synchronizer chain. It then watches for the edge that opens a frame under the chosen audio standard. Under the classic I2S standard a frame opens when word select falls. Under the left-justified, right-justified and PCM standards it opens when word select rises. An edge counts only if the block first samples the level before the edge and, in a later sample, the level after it.

When the opening edge is found, the block raises a one-cycle start pulse and then holds a synchronized flag high. The flag stays high until the enable input is cleared. With the asynchronous-start option set, the block must be enabled while word select still sits at its pre-edge level. If it is enabled at the wrong level, a sticky error flag is raised. The block still locks on the next valid opening edge.

Top module: `i2s_frame_sync`

## Requirements
- R1: While reset is high, and in the cycle after it, `synced`, `frame_start` and `level_err` are all 0.
- R2: `ws_in` passes through `SYNC_STAGES` (default 2) flops before edge detection. With the default, a `ws_in` level captured at clock edge k can raise `frame_start` at edge k+2 at the earliest. It is visible after that edge.
- R3: With `std_sel` = 2'b00 (classic I2S), the opening edge is a fall of word select: a sampled 1 followed by a sampled 0.
- R4: With `std_sel` = 2'b01 (left-justified), 2'b10 (right-justified) or 2'b11 (PCM), the opening edge is a rise of word select: a sampled 0 followed by a sampled 1.
- R5: The pre-edge level must be sampled while enabled before an edge counts. If word select already sits at the post-edge level when the block is enabled, no pulse occurs until it has gone to the pre-edge level and back.
- R6: `frame_start` is high for exactly one cycle, and at most once per enable period. Later word-select edges give no further pulse.
- R7: `synced` rises together with `frame_start` and stays high while `enable` stays high.
- R8: A cycle with `enable` low clears `synced` and `frame_start` at the next edge. Re-enabling requires a fresh pre-edge then post-edge sequence.
- R9: In the first enabled cycle, `level_err` is set if `async_start` is 1 and the synchronized word select is at the post-edge level. It is cleared if `async_start` is 0 or the level is correct.
- R10: `level_err` keeps its value until reset or the next enable rise, including across a disable. It does not prevent locking on a later valid opening edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst | input | 1 | Synchronous active-high reset |
| ws_in | input | 1 | Word-select line from the bus |
| enable | input | 1 | Interface enable |
| std_sel | input | 2 | Audio standard: 00 I2S, 01 left, 10 right, 11 PCM |
| async_start | input | 1 | Asynchronous-start option |
| synced | output | 1 | Frame alignment achieved |
| frame_start | output | 1 | One-cycle pulse at the opening edge |
| level_err | output | 1 | Enabled at the wrong word-select level |

## Verification
The checker watches several properties on every cycle:
- the pulse lasts one cycle and always comes with the synchronized flag;
- the flag holds while enabled and drops after a disabled cycle;
- each pulse follows a synchronized word-select sample at the correct post-edge level for the standard;
- the error flag only rises on an enable with the option set, and is stable while enable stays high.

Other behaviours can only be shown by the bench's scenarios. These are the exact latency through the synchronizer, the need to see the pre-edge level after enabling, the single pulse per enable period, and the error flag surviving a disable but clearing on a clean re-enable. A reference model runs alongside random word-select traffic to cover them.

// File: rtl/i2s_fs_pkg.sv
package i2s_fs_pkg;

    typedef enum logic [1:0] {
        STD_I2S   = 2'd0,
        STD_LEFT  = 2'd1,
        STD_RIGHT = 2'd2,
        STD_PCM   = 2'd3
    } audio_std_e;

    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,   // disabled, or first enabled cycle pending
        FS_HUNT   = 2'd1,   // waiting to sample the pre-edge level
        FS_ARMED  = 2'd2,   // pre-edge level seen, waiting for post-edge level
        FS_LOCKED = 2'd3    // opening edge found
    } fs_state_e;

    typedef struct packed {
        logic at_pre;
        logic at_post;
    } ws_class_t;

    // Word-select level that precedes the frame-opening edge.
    function automatic logic pre_edge_level(audio_std_e s);
        return (s == STD_I2S);
    endfunction

    function automatic ws_class_t classify_ws(logic ws, audio_std_e s);
        ws_class_t c;
        c.at_pre  = (ws == pre_edge_level(s));
        c.at_post = !c.at_pre;
        return c;
    endfunction

endpackage

// File: rtl/i2s_fs_ws_sync.sv
module i2s_fs_ws_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ws_in,
    output logic ws_s
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= ws_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign ws_s = chain[LAST];
endmodule

// File: rtl/i2s_fs_lock_fsm.sv
module i2s_fs_lock_fsm
    import i2s_fs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       ws_s,
    input  audio_std_e std,
    output logic       start,
    output logic       synced,
    output logic       en_rise,
    output logic       level_bad
);
    fs_state_e state, state_nx;
    logic      start_nx;
    ws_class_t cls;

    assign cls       = classify_ws(ws_s, std);
    assign en_rise   = enable && (state == FS_IDLE);
    assign level_bad = cls.at_post;

    always_comb begin
        state_nx = state;
        start_nx = 1'b0;
        if (!enable) begin
            state_nx = FS_IDLE;
        end else begin
            unique case (state)
                FS_IDLE:   state_nx = cls.at_pre ? FS_ARMED : FS_HUNT;
                FS_HUNT:   if (cls.at_pre) state_nx = FS_ARMED;
                FS_ARMED:  if (cls.at_post) begin
                               state_nx = FS_LOCKED;
                               start_nx = 1'b1;
                           end
                FS_LOCKED: state_nx = FS_LOCKED;
                default:   state_nx = FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FS_IDLE;
            start <= 1'b0;
        end else begin
            state <= state_nx;
            start <= start_nx;
        end
    end

    assign synced = (state == FS_LOCKED);
endmodule

// File: rtl/i2s_fs_err_track.sv
module i2s_fs_err_track (
    input  logic clk,
    input  logic rst,
    input  logic en_rise,
    input  logic async_start,
    input  logic level_bad,
    output logic level_err
);
    always_ff @(posedge clk) begin
        if (rst)          level_err <= 1'b0;
        else if (en_rise) level_err <= async_start && level_bad;
    end
endmodule

// File: rtl/i2s_frame_sync.sv
module i2s_frame_sync
    import i2s_fs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ws_in,
    input  logic       enable,
    input  logic [1:0] std_sel,
    input  logic       async_start,
    output logic       synced,
    output logic       frame_start,
    output logic       level_err
);
    logic       ws_s;
    logic       en_rise;
    logic       level_bad;
    audio_std_e std;

    assign std = audio_std_e'(std_sel);

    i2s_fs_ws_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .ws_in (ws_in),
        .ws_s  (ws_s)
    );

    i2s_fs_lock_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .ws_s      (ws_s),
        .std       (std),
        .start     (frame_start),
        .synced    (synced),
        .en_rise   (en_rise),
        .level_bad (level_bad)
    );

    i2s_fs_err_track u_err (
        .clk         (clk),
        .rst         (rst),
        .en_rise     (en_rise),
        .async_start (async_start),
        .level_bad   (level_bad),
        .level_err   (level_err)
    );
endmodule

// File: rtl/i2s_frame_sync_chk.sv
module i2s_frame_sync_chk (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic [1:0] std_sel,
    input logic       async_start,
    input logic       ws_s,
    input logic       synced,
    input logic       frame_start,
    input logic       level_err
);
    assert_start_single_R6: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !frame_start);

    assert_start_with_sync_R7: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> synced);

    assert_sync_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (synced && enable) |=> synced);

    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!synced && !frame_start));

    assert_i2s_falling_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_start && $past(std_sel) == 2'b00) |-> ($past(ws_s) == 1'b0));

    assert_other_rising_R4: assert property (@(posedge clk) disable iff (rst)
        (frame_start && $past(std_sel) != 2'b00) |-> ($past(ws_s) == 1'b1));

    assert_err_source_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(level_err) |-> ($past(async_start) && $past(enable)));

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(enable) && $past(enable, 2) && !$past(rst) && !$past(rst, 2))
        |-> $stable(level_err));
endmodule

bind i2s_frame_sync i2s_frame_sync_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .std_sel     (std_sel),
    .async_start (async_start),
    .ws_s        (ws_s),
    .synced      (synced),
    .frame_start (frame_start),
    .level_err   (level_err)
);

// File: tb/i2s_frame_sync_test.sv
`timescale 1ns/1ps
module i2s_frame_sync_test;
    localparam int STAGES = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ws_in = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] std_sel = 2'b00;
    logic       async_start = 1'b0;
    logic       synced, frame_start, level_err;

    int checks = 0;
    int errors = 0;

    // reference model state: 0 idle, 1 hunt, 2 armed, 3 locked
    int   m_state = 0;
    logic m_start = 0;
    logic m_err = 0;
    logic m_pipe [STAGES];

    always #2.5 clk = ~clk;

    i2s_frame_sync #(.SYNC_STAGES(STAGES)) uut (
        .clk(clk), .rst(rst), .ws_in(ws_in), .enable(enable),
        .std_sel(std_sel), .async_start(async_start),
        .synced(synced), .frame_start(frame_start), .level_err(level_err)
    );

    function automatic logic pre_lvl(logic [1:0] s);
        return (s == 2'b00);
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_state = 0; m_start = 0; m_err = 0;
        for (int i = 0; i < STAGES; i++) m_pipe[i] = 0;
    endtask

    task automatic model_edge();
        logic w;
        logic pre;
        w = m_pipe[STAGES-1];
        pre = pre_lvl(std_sel);
        m_start = 0;
        if (!enable) m_state = 0;
        else case (m_state)
            0: begin
                m_err = async_start && (w != pre);
                m_state = (w == pre) ? 2 : 1;
            end
            1: if (w == pre) m_state = 2;
            2: if (w != pre) begin m_state = 3; m_start = 1; end
            default: m_state = 3;
        endcase
        for (int i = STAGES - 1; i > 0; i--) m_pipe[i] = m_pipe[i-1];
        m_pipe[0] = ws_in;
    endtask

    // apply inputs at negedge, clock once, compare against model
    task automatic step(input logic ws, input logic en);
        ws_in = ws;
        enable = en;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(frame_start, m_start, (std_sel == 2'b00) ? "R3 frame_start" : "R4 frame_start");
        check(synced, (m_state == 3), "R7 synced");
        check(level_err, m_err, "R9 level_err");
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic ws_r;
        logic saw;
        void'($urandom(32'h5eed1234));
        model_reset();
        repeat (3) @(negedge clk);
        check(synced, 1'b0, "R1 synced in reset");
        check(frame_start, 1'b0, "R1 start in reset");
        check(level_err, 1'b0, "R1 err in reset");
        rst = 1'b0;
        step(1'b0, 1'b0);
        check(synced | frame_start | level_err, 1'b0, "R1 after reset");

        // classic I2S falling edge, exact latency
        std_sel = 2'b00; async_start = 1'b1;
        repeat (3) step(1'b1, 1'b0);
        repeat (3) step(1'b1, 1'b1);
        check(level_err, 1'b0, "R9 correct level no error");
        step(1'b0, 1'b1);
        check(frame_start, 1'b0, "R2 no pulse after capture edge");
        step(1'b0, 1'b1);
        check(frame_start, 1'b0, "R2 no pulse one edge later");
        step(1'b0, 1'b1);
        check(frame_start, 1'b1, "R3 pulse on falling edge at k+2");
        check(synced, 1'b1, "R7 synced with pulse");
        step(1'b0, 1'b1);
        check(frame_start, 1'b0, "R6 one-cycle pulse");
        saw = 0;
        for (int i = 0; i < 8; i++) begin
            step(i[1], 1'b1);
            saw |= frame_start;
        end
        check(saw, 1'b0, "R6 no second pulse");
        check(synced, 1'b1, "R7 synced held");
        step(1'b1, 1'b0);
        check(synced, 1'b0, "R8 disable clears synced");

        // PCM, enabled at post-edge level with option off
        std_sel = 2'b11; async_start = 1'b0;
        repeat (3) step(1'b1, 1'b0);
        saw = 0;
        for (int i = 0; i < 6; i++) begin step(1'b1, 1'b1); saw |= frame_start; end
        check(saw, 1'b0, "R5 post level alone gives no pulse");
        check(level_err, 1'b0, "R9 option off no error");
        repeat (4) step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        check(frame_start, 1'b1, "R4 pulse on rising edge");

        // wrong level with option on, left-justified
        step(1'b1, 1'b0);
        std_sel = 2'b01; async_start = 1'b1;
        repeat (3) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        check(level_err, 1'b1, "R9 wrong level flagged");
        repeat (3) step(1'b0, 1'b1);
        repeat (3) step(1'b1, 1'b1);
        check(synced, 1'b1, "R10 lock despite error");
        check(level_err, 1'b1, "R10 error sticky while enabled");
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        check(level_err, 1'b1, "R10 error survives disable");
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        check(level_err, 1'b0, "R10 cleared by clean enable");
        check(synced, 1'b0, "R8 fresh sequence needed");

        // random sessions
        for (int s = 0; s < 60; s++) begin
            std_sel = 2'($urandom_range(0, 3));
            async_start = 1'($urandom_range(0, 1));
            ws_r = 1'($urandom_range(0, 1));
            for (int i = 0; i < int'($urandom_range(1, 5)); i++) step(ws_r, 1'b0);
            for (int i = 0; i < int'($urandom_range(4, 50)); i++) begin
                if ($urandom_range(0, 3) == 0) ws_r = ~ws_r;
                step(ws_r, 1'b1);
            end
            if ($urandom_range(0, 9) == 0) begin
                rst = 1'b1;
                @(posedge clk);
                model_reset();
                @(negedge clk);
                check(synced | frame_start | level_err, 1'b0, "R1 mid-run reset");
                rst = 1'b0;
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule